// File: doc/BRIEF.md
# Double-Buffered Configuration Register Bank

This block is a byte-wide configuration store that sits behind a simple write/read port: one write strobe, one address, one write byte and a combinational read byte. Most registers keep two copies. Software writes reach the staging copy only. The value the rest of the chip sees is the working copy. A single update command copies every staged value into the working outputs on the same clock edge. Several registers can therefore be changed together without the logic downstream ever seeing a half-written set.

Some registers bypass staging and take effect on the edge that accepts the write. A one-shot command register loads its bits at an update. Each bit then clears itself when the matching completion input reports that the action is done. Two read-only bytes reflect external status. A live guard bit can lock a protected group of registers. While it is set, that group reads as zero and ignores writes, and this includes a status byte that is also read-only. Addresses that hold no register read zero and ignore writes.

The working outputs are a multi-byte parameter word, a mode byte, a live byte and the one-shot command byte, plus the one-cycle commit pulse.

Top module: `cfg_regbank`

## Requirements
- R1: After reset every working output, every staging copy, the guard and the commit pulse are zero.
- R2: A write to a staged register (parameter bytes at 0x0100 + k, mode byte at 0x0120) changes what that address reads back from the next cycle on. It leaves the working output unchanged until an update.
- R3: Writing exactly 0x01 to 0x000F raises `commit_o` for one cycle, starting the cycle after the write. All working copies load their staged values at the end of that cycle. Any other byte written there does nothing. The address reads 0x01 while the pulse is pending and 0x00 otherwise.
- R4: The parameter word is stored lowest byte first: `param_o[8k+7:8k]` is the working copy of address 0x0100 + k.
- R5: A write to the live byte at 0x0200 or to the guard at 0x0010 takes effect on the accepting edge, with no update needed.
- R6: The one-shot byte at 0x0300 is staged. An update copies it to `ac_o` and zeroes its staging copy. Any working bit whose `done_i` bit is high at an edge clears on that edge, unless a commit happens on the same edge. The address reads the working value.
- R7: Addresses 0x0400 and 0x0401 read `status_i[7:0]` and `status_i[15:8]` and ignore writes.
- R8: Any address without a register reads 0x00, and a write to it changes no output and no readback.
- R9: While guard bit 0 is set, the parameter bytes, the mode byte and the status byte at 0x0401 read 0x00 and ignore writes. The most restrictive class wins. Once the guard clears, earlier values read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe, one byte accepted per edge |
| addr_i | input | 13 | Byte address for write and read |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Read byte for `addr_i` (combinational) |
| status_i | input | 16 | External status shown by the read-only bytes |
| done_i | input | 8 | Per-bit completion for the one-shot byte |
| param_o | output | 8*PARAM_BYTES | Working parameter word |
| mode_o | output | 8 | Working mode byte |
| live_o | output | 8 | Live byte |
| ac_o | output | 8 | Working one-shot bits |
| commit_o | output | 1 | One-cycle update pulse |

## Verification
The assertions check several rules on every cycle. The staged outputs hold still except on a commit edge. The commit pulse is exactly one cycle long and follows a key write. The live byte follows its write. A completion bit never leaves its one-shot bit set. Addresses beyond the map always read zero. The bench's scenarios show the rest, because these depend on history: the lowest-byte-first order of the word, the readback of staged values, the guard that hides values and later reveals them intact, and the one-shot staging copy that is emptied at commit. The bench compares every address of the space against a reference model at reset, after directed sequences and after a random mix of writes and updates.

// File: rtl/cfg_regbank_pkg.sv
package cfg_regbank_pkg;
  localparam int unsigned ADDR_W   = 13;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned SLOT_W   = 5;
  localparam int unsigned ADDR_MAX = 'h1788;
  localparam int unsigned UPD_A    = 'h000F;
  localparam int unsigned GUARD_A  = 'h0010;
  localparam int unsigned PARAM_A  = 'h0100;
  localparam int unsigned MODE_A   = 'h0120;
  localparam int unsigned LIVE_A   = 'h0200;
  localparam int unsigned AUTO_A   = 'h0300;
  localparam int unsigned STAT_A   = 'h0400;
  localparam logic [DATA_W-1:0] UPD_KEY = 8'h01;

  typedef enum logic [2:0] {K_NONE, K_BUF, K_LIVE, K_AUTO, K_STAT, K_UPD} kind_e;

  typedef struct packed {
    kind_e             kind;
    logic              ro;
    logic              prot;
    logic [SLOT_W-1:0] slot;
  } attr_t;

  // slot order: param bytes, mode, live, one-shot, guard
  function automatic kind_e slot_kind(input int unsigned s, input int unsigned pb);
    if (s <= pb) return K_BUF;
    if (s == pb + 2) return K_AUTO;
    return K_LIVE;
  endfunction

  function automatic attr_t lookup(input logic [ADDR_W-1:0] a, input int unsigned pb);
    attr_t       r;
    int unsigned ai;
    ai = 32'(a);
    r  = '{kind: K_NONE, ro: 1'b0, prot: 1'b0, slot: '0};
    if (ai == UPD_A) begin
      r.kind = K_UPD;
    end else if (ai == GUARD_A) begin
      r.kind = K_LIVE;
      r.slot = SLOT_W'(pb + 3);
    end else if (ai >= PARAM_A && ai < PARAM_A + pb) begin
      r.kind = K_BUF;
      r.prot = 1'b1;
      r.slot = SLOT_W'(ai - PARAM_A);
    end else if (ai == MODE_A) begin
      r.kind = K_BUF;
      r.prot = 1'b1;
      r.slot = SLOT_W'(pb);
    end else if (ai == LIVE_A) begin
      r.kind = K_LIVE;
      r.slot = SLOT_W'(pb + 1);
    end else if (ai == AUTO_A) begin
      r.kind = K_AUTO;
      r.slot = SLOT_W'(pb + 2);
    end else if (ai == STAT_A) begin
      r.kind = K_STAT;
      r.ro   = 1'b1;
    end else if (ai == STAT_A + 1) begin
      r.kind = K_STAT;
      r.ro   = 1'b1;
      r.prot = 1'b1;
      r.slot = SLOT_W'(1);
    end
    return r;
  endfunction
endpackage

// File: rtl/cfg_regbank_decode.sv
module cfg_regbank_decode
  import cfg_regbank_pkg::*;
#(
  parameter int unsigned PARAM_BYTES = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              prot_en_i,
  output attr_t             attr_o,
  output logic              rd_ok_o,
  output logic              wr_ok_o
);
  logic denied;

  always_comb begin
    attr_o  = lookup(addr_i, PARAM_BYTES);
    // most restrictive class wins: unmapped / guarded beat read-only
    denied  = (attr_o.kind == K_NONE) || (attr_o.prot && prot_en_i);
    rd_ok_o = !denied;
    wr_ok_o = !denied && !attr_o.ro;
  end
endmodule

// File: rtl/cfg_regbank_update.sv
module cfg_regbank_update (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic key_we_i,
  output logic pend_o
);
  // self-clearing: set for exactly one cycle per key write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= 1'b0;
    else         pend_o <= key_we_i & ~pend_o;
  end
endmodule

// File: rtl/cfg_regbank_cell.sv
module cfg_regbank_cell
  import cfg_regbank_pkg::*;
#(
  parameter kind_e       KIND = K_BUF,
  parameter int unsigned W    = DATA_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         commit_i,
  input  logic [W-1:0] done_i,
  output logic [W-1:0] rd_o,
  output logic [W-1:0] act_o
);
  if (KIND == K_LIVE) begin : g_live
    logic unused_live;
    assign unused_live = ^{commit_i, done_i};
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   act_o <= '0;
      else if (we_i) act_o <= wdata_i;
    end
    assign rd_o = act_o;
  end else if (KIND == K_AUTO) begin : g_auto
    logic [W-1:0] stage_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q <= '0;
        act_o   <= '0;
      end else begin
        if (commit_i) begin
          act_o   <= stage_q;
          stage_q <= '0;
        end else begin
          act_o <= act_o & ~done_i;
        end
        if (we_i) stage_q <= wdata_i;
      end
    end
    assign rd_o = act_o;
  end else begin : g_buf
    logic [W-1:0] stage_q;
    logic         unused_buf;
    assign unused_buf = ^done_i;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q <= '0;
        act_o   <= '0;
      end else begin
        if (we_i)     stage_q <= wdata_i;
        if (commit_i) act_o   <= stage_q;
      end
    end
    assign rd_o = stage_q;
  end
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
  import cfg_regbank_pkg::*;
#(
  parameter int unsigned PARAM_BYTES = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic [DATA_W-1:0]        rdata_o,
  input  logic [2*DATA_W-1:0]      status_i,
  input  logic [DATA_W-1:0]        done_i,
  output logic [8*PARAM_BYTES-1:0] param_o,
  output logic [DATA_W-1:0]        mode_o,
  output logic [DATA_W-1:0]        live_o,
  output logic [DATA_W-1:0]        ac_o,
  output logic                     commit_o
);
  localparam int unsigned NSLOT      = PARAM_BYTES + 4;
  localparam int unsigned MODE_SLOT  = PARAM_BYTES;
  localparam int unsigned LIVE_SLOT  = PARAM_BYTES + 1;
  localparam int unsigned AUTO_SLOT  = PARAM_BYTES + 2;
  localparam int unsigned GUARD_SLOT = PARAM_BYTES + 3;

  attr_t                        attr;
  logic                         rd_ok, wr_ok, wr_go, pend, prot_en, key_we;
  logic [NSLOT-1:0][DATA_W-1:0] rd_val, act_val;

  assign prot_en = act_val[GUARD_SLOT][0];
  assign wr_go   = wr_en_i & wr_ok;
  assign key_we  = wr_go && (attr.kind == K_UPD) && (wdata_i == UPD_KEY);

  cfg_regbank_decode #(.PARAM_BYTES(PARAM_BYTES)) u_dec (
    .addr_i   (addr_i),
    .prot_en_i(prot_en),
    .attr_o   (attr),
    .rd_ok_o  (rd_ok),
    .wr_ok_o  (wr_ok)
  );

  cfg_regbank_update u_upd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .key_we_i(key_we),
    .pend_o  (pend)
  );

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    localparam kind_e SK = slot_kind(s, PARAM_BYTES);
    logic we;
    assign we = wr_go && (attr.kind == SK) && (attr.slot == SLOT_W'(s));
    cfg_regbank_cell #(.KIND(SK), .W(DATA_W)) u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (we),
      .wdata_i (wdata_i),
      .commit_i(pend),
      .done_i  (done_i),
      .rd_o    (rd_val[s]),
      .act_o   (act_val[s])
    );
  end

  for (genvar k = 0; k < PARAM_BYTES; k++) begin : g_param
    assign param_o[8*k +: 8] = act_val[k];
  end

  assign mode_o   = act_val[MODE_SLOT];
  assign live_o   = act_val[LIVE_SLOT];
  assign ac_o     = act_val[AUTO_SLOT];
  assign commit_o = pend;

  always_comb begin
    rdata_o = '0;
    if (rd_ok) begin
      unique case (attr.kind)
        K_UPD:  rdata_o = {{(DATA_W-1){1'b0}}, pend};
        K_STAT: rdata_o = attr.slot[0] ? status_i[2*DATA_W-1:DATA_W] : status_i[DATA_W-1:0];
        K_BUF, K_LIVE, K_AUTO: begin
          for (int s = 0; s < NSLOT; s++)
            if (attr.slot == SLOT_W'(s)) rdata_o = rd_val[s];
        end
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/cfg_regbank_chk.sv
module cfg_regbank_chk
  import cfg_regbank_pkg::*;
#(
  parameter int unsigned PARAM_BYTES = 4
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     wr_en_i,
  input logic [ADDR_W-1:0]        addr_i,
  input logic [DATA_W-1:0]        wdata_i,
  input logic [DATA_W-1:0]        rdata_o,
  input logic [2*DATA_W-1:0]      status_i,
  input logic [DATA_W-1:0]        done_i,
  input logic [8*PARAM_BYTES-1:0] param_o,
  input logic [DATA_W-1:0]        mode_o,
  input logic [DATA_W-1:0]        live_o,
  input logic [DATA_W-1:0]        ac_o,
  input logic                     commit_o
);
  logic key_wr, live_wr;
  assign key_wr  = wr_en_i && (32'(addr_i) == UPD_A) && (wdata_i == UPD_KEY);
  assign live_wr = wr_en_i && (32'(addr_i) == LIVE_A);

  a_r3_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o);

  a_r3_key_commits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_wr && !commit_o) |=> commit_o);

  a_r3_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !key_wr |=> !commit_o);

  a_r2_active_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_o |=> ($stable(param_o) && $stable(mode_o)));

  a_r5_live_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_wr |=> (live_o == $past(wdata_i)));

  a_r5_live_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !live_wr |=> $stable(live_o));

  a_r6_done_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_o |=> ((ac_o & $past(done_i)) == '0));

  a_r8_beyond_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(addr_i) > ADDR_MAX) |-> (rdata_o == '0));

  a_r7_status_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(addr_i) == STAT_A) |-> (rdata_o == status_i[DATA_W-1:0]));
endmodule

bind cfg_regbank cfg_regbank_chk #(.PARAM_BYTES(PARAM_BYTES)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .status_i(status_i),
  .done_i  (done_i),
  .param_o (param_o),
  .mode_o  (mode_o),
  .live_o  (live_o),
  .ac_o    (ac_o),
  .commit_o(commit_o)
);

// File: tb/cfg_regbank_bench.sv
module cfg_regbank_bench;
  localparam int PB = 4;

  logic          clk = 1'b0, rst_ni = 1'b0;
  logic          wr_en = 1'b0;
  logic [12:0]   addr = '0;
  logic [7:0]    wdata = '0, rdata, done = '0, mode_o, live_o, ac_o;
  logic [15:0]   status = 16'h0000;
  logic [8*PB-1:0] param_o;
  logic          commit_o;

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [7:0] m_pbuf [PB], m_pact [PB];
  logic [7:0] m_mbuf, m_mact, m_live, m_abuf, m_aact, m_guard;

  always #4 clk = ~clk;

  cfg_regbank #(.PARAM_BYTES(PB)) u_cfg_regbank (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .status_i(status), .done_i(done), .param_o(param_o),
    .mode_o(mode_o), .live_o(live_o), .ac_o(ac_o), .commit_o(commit_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input int a);
    bit p = m_guard[0];
    if (a == 'h00F) return 8'h00;
    if (a == 'h010) return m_guard;
    if (a >= 'h100 && a < 'h100 + PB) return p ? 8'h00 : m_pbuf[a - 'h100];
    if (a == 'h120) return p ? 8'h00 : m_mbuf;
    if (a == 'h200) return m_live;
    if (a == 'h300) return m_aact;
    if (a == 'h400) return status[7:0];
    if (a == 'h401) return p ? 8'h00 : status[15:8];
    return 8'h00;
  endfunction

  function automatic logic [31:0] exp_param();
    logic [31:0] v = 0;
    for (int k = 0; k < PB; k++) v = v + (32'(m_pact[k]) << (8 * k));
    return v;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < PB; k++) begin m_pbuf[k] = 0; m_pact[k] = 0; end
    m_mbuf = 0; m_mact = 0; m_live = 0; m_abuf = 0; m_aact = 0; m_guard = 0;
  endtask

  task automatic model_write(input int a, input logic [7:0] d);
    bit p = m_guard[0];
    if (a == 'h010) m_guard = d;
    else if (a >= 'h100 && a < 'h100 + PB) begin if (!p) m_pbuf[a - 'h100] = d; end
    else if (a == 'h120) begin if (!p) m_mbuf = d; end
    else if (a == 'h200) m_live = d;
    else if (a == 'h300) m_abuf = d;
  endtask

  task automatic model_commit();
    for (int k = 0; k < PB; k++) m_pact[k] = m_pbuf[k];
    m_mact = m_mbuf; m_aact = m_abuf; m_abuf = 0;
  endtask

  task automatic chk_outs(input string tag);
    chk({tag, " R4 param_o"}, param_o, exp_param());
    chk({tag, " R2 mode_o"}, 32'(mode_o), 32'(m_mact));
    chk({tag, " R5 live_o"}, 32'(live_o), 32'(m_live));
    chk({tag, " R6 ac_o"}, 32'(ac_o), 32'(m_aact));
  endtask

  task automatic do_wr(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = 13'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
    if (a == 'h00F && d == 8'h01) begin
      chk("R3 commit pulse raised", 32'(commit_o), 1);
      addr = 13'h00F; #1;
      chk("R3 update reg pending", 32'(rdata), 1);
      @(negedge clk);
      model_commit();
      chk("R3 commit pulse one cycle", 32'(commit_o), 0);
    end else begin
      chk("R3 no commit", 32'(commit_o), 0);
    end
  endtask

  task automatic chk_rd(input int a, input string tag);
    @(negedge clk);
    addr = 13'(a); #1;
    chk($sformatf("%s addr=%h", tag, a), 32'(rdata), 32'(exp_rd(a)));
  endtask

  task automatic sweep(input string tag);
    for (int a = 0; a < 8192; a++) chk_rd(a, tag);
  endtask

  initial begin
    model_reset();
    status = 16'hBEEF;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state, R7/R8 full map
    chk_outs("R1 reset");
    chk("R1 commit reset", 32'(commit_o), 0);
    sweep("R1 R7 R8 reset read");

    // R2/R4 staged word
    do_wr('h100, 8'h11); do_wr('h101, 8'h22); do_wr('h102, 8'h33); do_wr('h103, 8'h44);
    do_wr('h120, 8'h5A);
    chk_outs("R2 staged only");
    chk_rd('h102, "R2 staged readback");
    do_wr('h00F, 8'h02);
    chk_outs("R3 wrong key ignored");
    do_wr('h00F, 8'h01);
    chk("R4 byte order", param_o, 32'h44332211);
    chk_outs("R3 after update");
    chk_rd('h00F, "R3 update reg cleared");

    // R5 live
    do_wr('h200, 8'hC3);
    chk("R5 live immediate", 32'(live_o), 32'hC3);

    // R6 one-shot
    do_wr('h300, 8'h0F);
    chk("R6 staged not active", 32'(ac_o), 0);
    do_wr('h00F, 8'h01);
    chk("R6 committed", 32'(ac_o), 32'h0F);
    chk_rd('h300, "R6 reads active");
    @(negedge clk); done = 8'h05;
    @(negedge clk); done = 8'h00;
    m_aact = m_aact & ~8'h05;
    chk("R6 done clears", 32'(ac_o), 32'h0A);
    do_wr('h00F, 8'h01);
    chk("R6 staging emptied", 32'(ac_o), 0);

    // R7 read-only
    do_wr('h400, 8'h00); do_wr('h401, 8'h00);
    chk_rd('h400, "R7 status lo"); chk_rd('h401, "R7 status hi");
    status = 16'h1234;
    chk_rd('h401, "R7 status follows");

    // R9 guard
    do_wr('h010, 8'h01);
    chk_rd('h101, "R9 guarded reads zero");
    chk_rd('h401, "R9 guarded ro reads zero");
    do_wr('h101, 8'hEE); do_wr('h120, 8'hEE);
    do_wr('h00F, 8'h01);
    chk_outs("R9 guarded writes ignored");
    do_wr('h010, 8'h00);
    chk_rd('h101, "R9 value intact"); chk_rd('h120, "R9 mode intact");

    // R8 unmapped
    do_wr('h000, 8'hFF); do_wr('h150, 8'hFF); do_wr('h1788, 8'hFF); do_wr('h1FFF, 8'hFF);
    do_wr('h00F, 8'h01);
    chk_outs("R8 unmapped write");
    sweep("R8 after unmapped write");

    // mixed sequence
    for (int i = 0; i < 400; i++) begin
      int pool [15] = '{'h00F, 'h010, 'h100, 'h101, 'h102, 'h103, 'h120, 'h200,
                        'h300, 'h400, 'h401, 'h000, 'h150, 'h1788, 'h1FFF};
      int a = pool[$urandom_range(0, 14)];
      logic [7:0] d = 8'($urandom_range(0, 255));
      if (a == 'h00F && $urandom_range(0, 1) == 1) d = 8'h01;
      if (a == 'h010) d = {7'b0, d[0]};
      do_wr(a, d);
      chk_outs("R2 R5 mixed");
      chk_rd(a, "R9 mixed readback");
    end
    sweep("R8 R9 final read");

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule